// File: doc/BRIEF.md
# Aliased Sub-Register File

This block holds eight 32-bit general registers behind two combinational read ports and one clocked write port. Every access carries a register index and a two-bit part selector. The selector picks the full 32-bit register, its low 16-bit word, or one of the two bytes inside that low word. Byte access exists only on registers 0 to 3. All parts are views of the same storage, so a narrow write merges into the register that holds it and is visible through every other view.

Each read port also reports whether the register it points at may be used as an address index. Register 4 holds the stack pointer and is the only one that may not. A request for a byte part on registers 4 to 7 is illegal. A write of that kind raises an error and changes nothing. A read of that kind raises an error and returns zero.

Top module: `alias_regfile`

## Requirements
- R1: While rst_ni is low, every register is cleared to zero, so after reset every part of every register reads back as zero.
- R2: A legal write with part 00 (full register) replaces all 32 bits. A read with part 00 returns all 32 bits unchanged.
- R3: idx_ok_a_o and idx_ok_b_o are low when their read index is 4 and high for the seven other indices.
- R4: A write with part 01 (low word) loads bits 15:0 from wdata_i[15:0] and leaves bits 31:16 unchanged.
- R5: On registers 0 to 3, a write with part 10 (high byte) loads bits 15:8 from wdata_i[7:0], and a write with part 11 (low byte) loads bits 7:0 from wdata_i[7:0]. All other bits are unchanged.
- R6: Part 10 or 11 with an index of 4 to 7 is illegal. On the write port, werr_o goes high while we_i is high and the register file is left unchanged. On a read port, the error output goes high and the read data is zero.
- R7: A low-word read returns bits 15:0 with bits 31:16 zero. A high-byte read returns register bits 15:8 in bits 7:0. A low-byte read returns bits 7:0. In both byte reads bits 31:8 are zero.
- R8: Reads are combinational. A write takes effect at the rising clock edge, so a read of the register being written in that same cycle returns the old value.
- R9: Both read ports work independently and see every part of the shared storage, so a write through any part is visible through every overlapping part.
- R10: While we_i is low the register file keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write request |
| waddr_i | input | 3 | Write register index |
| wpart_i | input | 2 | Write part: 00 full, 01 low word, 10 high byte, 11 low byte |
| wdata_i | input | 32 | Write data, right-aligned for narrow parts |
| werr_o | output | 1 | Illegal write request, write suppressed |
| raddr_a_i | input | 3 | Read port A register index |
| rpart_a_i | input | 2 | Read port A part |
| rdata_a_o | output | 32 | Read port A data, zero-extended |
| rerr_a_o | output | 1 | Read port A illegal part |
| idx_ok_a_o | output | 1 | Port A register may serve as an index |
| raddr_b_i | input | 3 | Read port B register index |
| rpart_b_i | input | 2 | Read port B part |
| rdata_b_o | output | 32 | Read port B data, zero-extended |
| rerr_b_o | output | 1 | Read port B illegal part |
| idx_ok_b_o | output | 1 | Port B register may serve as an index |

## Verification
Directed sequences first write a full known pattern and then overlay a word, a high byte and a low byte on it. This separates a correct merge from one that clears or shifts the untouched bits. A same-cycle read of the register being written tells a clocked write apart from a write that passes straight through to the read port. Byte requests aimed at registers 4 to 7 check that the write is suppressed and that the read returns zero. A long random mix of indices, parts and write enables then drives both read ports at once against a bench model, which catches wrong aliasing between parts and crossed ports.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  typedef enum logic [1:0] {
    PART_DWORD = 2'b00,
    PART_WORD  = 2'b01,
    PART_HIGH  = 2'b10,
    PART_LOW   = 2'b11
  } part_e;

  function automatic logic part_is_byte(part_e p);
    return (p == PART_HIGH) || (p == PART_LOW);
  endfunction
endpackage

// File: rtl/alias_part_decode.sv
module alias_part_decode
  import alias_rf_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  parameter int NOIDX_REG = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  part_e            part_i,
  output logic             legal_o,
  output logic             idx_ok_o
);
  // byte views only exist on the low BYTE_REGS registers
  always_comb begin
    legal_o = 1'b1;
    if (part_is_byte(part_i) && (int'(idx_i) >= BYTE_REGS)) legal_o = 1'b0;
  end

  assign idx_ok_o = (int'(idx_i) != NOIDX_REG);
endmodule

// File: rtl/alias_read_mux.sv
module alias_read_mux
  import alias_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic [DATA_W-1:0] reg_i,
  input  part_e             part_i,
  input  logic              legal_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (legal_i) begin
      unique case (part_i)
        PART_DWORD: data_o = reg_i;
        PART_WORD:  data_o[WORD_W-1:0] = reg_i[WORD_W-1:0];
        PART_HIGH:  data_o[BYTE_W-1:0] = reg_i[WORD_W-1:BYTE_W];
        PART_LOW:   data_o[BYTE_W-1:0] = reg_i[BYTE_W-1:0];
        default:    data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/alias_write_merge.sv
module alias_write_merge
  import alias_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  part_e             part_i,
  output logic [DATA_W-1:0] new_o
);
  always_comb begin
    new_o = old_i;
    unique case (part_i)
      PART_DWORD: new_o = wdata_i;
      PART_WORD:  new_o[WORD_W-1:0] = wdata_i[WORD_W-1:0];
      PART_HIGH:  new_o[WORD_W-1:BYTE_W] = wdata_i[BYTE_W-1:0];
      PART_LOW:   new_o[BYTE_W-1:0] = wdata_i[BYTE_W-1:0];
      default:    new_o = old_i;
    endcase
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_rf_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int WORD_W    = 16,
  parameter int BYTE_REGS = 4,
  parameter int NOIDX_REG = 4,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int NUM_RD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [1:0]        wpart_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              werr_o,
  input  logic [IDX_W-1:0]  raddr_a_i,
  input  logic [1:0]        rpart_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic              rerr_a_o,
  output logic              idx_ok_a_o,
  input  logic [IDX_W-1:0]  raddr_b_i,
  input  logic [1:0]        rpart_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              rerr_b_o,
  output logic              idx_ok_b_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_flat;

  // write path
  logic              wr_legal;
  logic              wr_idx_ok_unused;
  logic [DATA_W-1:0] wr_val;
  logic              wr_fire;

  alias_part_decode #(
    .NUM_REGS (NUM_REGS),
    .BYTE_REGS(BYTE_REGS),
    .NOIDX_REG(NOIDX_REG)
  ) u_wdec (
    .idx_i   (waddr_i),
    .part_i  (part_e'(wpart_i)),
    .legal_o (wr_legal),
    .idx_ok_o(wr_idx_ok_unused)
  );

  alias_write_merge #(
    .DATA_W(DATA_W),
    .WORD_W(WORD_W)
  ) u_merge (
    .old_i  (regs_q[waddr_i]),
    .wdata_i(wdata_i),
    .part_i (part_e'(wpart_i)),
    .new_o  (wr_val)
  );

  assign wr_fire = we_i && wr_legal;
  assign werr_o  = we_i && !wr_legal;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (wr_fire && (int'(waddr_i) == g)) begin
        regs_q[g] <= wr_val;
      end
    end
    assign regs_flat[g] = regs_q[g];
  end

  // read ports
  logic [IDX_W-1:0]  rd_idx   [NUM_RD];
  logic [1:0]        rd_part  [NUM_RD];
  logic [DATA_W-1:0] rd_data  [NUM_RD];
  logic              rd_legal [NUM_RD];
  logic              rd_idxok [NUM_RD];

  assign rd_idx[0]  = raddr_a_i;
  assign rd_part[0] = rpart_a_i;
  assign rd_idx[1]  = raddr_b_i;
  assign rd_part[1] = rpart_b_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    alias_part_decode #(
      .NUM_REGS (NUM_REGS),
      .BYTE_REGS(BYTE_REGS),
      .NOIDX_REG(NOIDX_REG)
    ) u_rdec (
      .idx_i   (rd_idx[p]),
      .part_i  (part_e'(rd_part[p])),
      .legal_o (rd_legal[p]),
      .idx_ok_o(rd_idxok[p])
    );

    alias_read_mux #(
      .DATA_W(DATA_W),
      .WORD_W(WORD_W)
    ) u_rmux (
      .reg_i  (regs_q[rd_idx[p]]),
      .part_i (part_e'(rd_part[p])),
      .legal_i(rd_legal[p]),
      .data_o (rd_data[p])
    );
  end

  assign rdata_a_o  = rd_data[0];
  assign rerr_a_o   = !rd_legal[0];
  assign idx_ok_a_o = rd_idxok[0];
  assign rdata_b_o  = rd_data[1];
  assign rerr_b_o   = !rd_legal[1];
  assign idx_ok_b_o = rd_idxok[1];
endmodule

// File: rtl/alias_regfile_sva.sv
module alias_regfile_sva #(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int WORD_W    = 16,
  parameter int BYTE_REGS = 4,
  parameter int NOIDX_REG = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            we_i,
  input logic [IDX_W-1:0]                waddr_i,
  input logic [1:0]                      wpart_i,
  input logic                            werr_o,
  input logic [IDX_W-1:0]                raddr_a_i,
  input logic [1:0]                      rpart_a_i,
  input logic [DATA_W-1:0]               rdata_a_o,
  input logic                            rerr_a_o,
  input logic                            idx_ok_a_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_i
);
  // R4
  p_word_keeps_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !werr_o && wpart_i == 2'b01) |=>
      (regs_i[$past(waddr_i)][DATA_W-1:WORD_W] == $past(regs_i[waddr_i][DATA_W-1:WORD_W])));

  // R6
  p_illegal_write_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wpart_i[1] && int'(waddr_i) >= BYTE_REGS) |-> werr_o);

  p_illegal_write_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    werr_o |=> $stable(regs_i));

  p_illegal_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_a_o |-> (rdata_a_o == '0));

  // R10
  p_idle_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_i));

  // R7
  p_word_zero_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpart_a_i == 2'b01) |-> (rdata_a_o[DATA_W-1:WORD_W] == '0));

  // R3
  p_stack_not_index_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(raddr_a_i) == NOIDX_REG) |-> !idx_ok_a_o);
endmodule

bind alias_regfile alias_regfile_sva #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .WORD_W   (WORD_W),
  .BYTE_REGS(BYTE_REGS),
  .NOIDX_REG(NOIDX_REG)
) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .waddr_i   (waddr_i),
  .wpart_i   (wpart_i),
  .werr_o    (werr_o),
  .raddr_a_i (raddr_a_i),
  .rpart_a_i (rpart_a_i),
  .rdata_a_o (rdata_a_o),
  .rerr_a_o  (rerr_a_o),
  .idx_ok_a_o(idx_ok_a_o),
  .regs_i    (regs_flat)
);

// File: tb/alias_regfile_test.sv
`timescale 1ns/1ps
module alias_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  waddr_i = '0;
  logic [1:0]  wpart_i = '0;
  logic [31:0] wdata_i = '0;
  logic        werr_o;
  logic [2:0]  raddr_a_i = '0;
  logic [1:0]  rpart_a_i = '0;
  logic [31:0] rdata_a_o;
  logic        rerr_a_o;
  logic        idx_ok_a_o;
  logic [2:0]  raddr_b_i = '0;
  logic [1:0]  rpart_b_i = '0;
  logic [31:0] rdata_b_o;
  logic        rerr_b_o;
  logic        idx_ok_b_o;

  int vectors = 0;
  int misses  = 0;
  logic [31:0] model [8];

  always #10 clk_i = ~clk_i;

  alias_regfile uut (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wpart_i, .wdata_i, .werr_o,
    .raddr_a_i, .rpart_a_i, .rdata_a_o, .rerr_a_o, .idx_ok_a_o,
    .raddr_b_i, .rpart_b_i, .rdata_b_o, .rerr_b_o, .idx_ok_b_o
  );

  function automatic logic legal(logic [2:0] idx, logic [1:0] part);
    return !(part[1] && idx >= 3'd4);
  endfunction

  function automatic logic [31:0] exp_read(logic [31:0] r, logic [2:0] idx, logic [1:0] part);
    if (!legal(idx, part)) return 32'h0;
    case (part)
      2'b00:   return r;
      2'b01:   return {16'h0, r[15:0]};
      2'b10:   return {24'h0, r[15:8]};
      default: return {24'h0, r[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] exp_merge(logic [31:0] r, logic [31:0] d, logic [1:0] part);
    case (part)
      2'b00:   return d;
      2'b01:   return {r[31:16], d[15:0]};
      2'b10:   return {r[31:16], d[7:0], r[7:0]};
      default: return {r[31:8], d[7:0]};
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [2:0] wa, logic [1:0] wp, logic [31:0] wd,
                      logic [2:0] ra, logic [1:0] pa, logic [2:0] rb, logic [1:0] pb,
                      string tag);
    @(negedge clk_i);
    we_i = we; waddr_i = wa; wpart_i = wp; wdata_i = wd;
    raddr_a_i = ra; rpart_a_i = pa; raddr_b_i = rb; rpart_b_i = pb;
    #2;
    check(tag, rdata_a_o, exp_read(model[ra], ra, pa));
    check(tag, rdata_b_o, exp_read(model[rb], rb, pb));
    check("R6 rerr_a", {31'h0, rerr_a_o}, {31'h0, !legal(ra, pa)});
    check("R6 rerr_b", {31'h0, rerr_b_o}, {31'h0, !legal(rb, pb)});
    check("R6 werr", {31'h0, werr_o}, {31'h0, we && !legal(wa, wp)});
    check("R3 idx_ok_a", {31'h0, idx_ok_a_o}, {31'h0, ra != 3'd4});
    check("R3 idx_ok_b", {31'h0, idx_ok_b_o}, {31'h0, rb != 3'd4});
    @(posedge clk_i);
    if (we && legal(wa, wp)) model[wa] = exp_merge(model[wa], wd, wp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < 8; i++)
      step(1'b0, 3'd0, 2'b00, 32'h0, 3'(i), 2'b00, 3'(i), 2'b01, "R1 reset");

    // R2 full write, R8 same-cycle read returns old value
    step(1'b1, 3'd2, 2'b00, 32'hA5A5_1234, 3'd2, 2'b00, 3'd2, 2'b01, "R8 old value");
    step(1'b0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b00, 3'd2, 2'b00, "R2 full");
    // R4 word write keeps upper half
    step(1'b1, 3'd2, 2'b01, 32'hFFFF_BEEF, 3'd2, 2'b00, 3'd0, 2'b00, "R4 word");
    step(1'b0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b00, 3'd2, 2'b01, "R4 word");
    // R5 byte writes: A5A5_BEEF -> A5A5_77EF -> A5A5_7711
    step(1'b1, 3'd2, 2'b10, 32'hCCCC_CC77, 3'd2, 2'b00, 3'd2, 2'b10, "R5 high");
    step(1'b1, 3'd2, 2'b11, 32'hDDDD_DD11, 3'd2, 2'b00, 3'd2, 2'b11, "R5 low");
    step(1'b0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b00, 3'd2, 2'b00, "R5 merged");
    // R7 zero-extended narrow reads, R9 aliasing across ports
    step(1'b0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b10, 3'd2, 2'b01, "R7 R9 narrow");
    step(1'b0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b11, 3'd4, 2'b00, "R7 low byte");
    // R6 byte write on register 5 is rejected, byte read gives zero
    step(1'b1, 3'd5, 2'b00, 32'h1357_9BDF, 3'd5, 2'b00, 3'd5, 2'b00, "R6 setup");
    step(1'b1, 3'd5, 2'b10, 32'h0000_00EE, 3'd5, 2'b00, 3'd5, 2'b10, "R6 illegal");
    step(1'b1, 3'd7, 2'b11, 32'h0000_00EE, 3'd5, 2'b00, 3'd7, 2'b11, "R6 unchanged");
    step(1'b0, 3'd0, 2'b00, 32'h0, 3'd5, 2'b00, 3'd7, 2'b00, "R6 unchanged");
    // R10 no write while we_i low
    step(1'b0, 3'd3, 2'b00, 32'hFFFF_FFFF, 3'd3, 2'b00, 3'd3, 2'b00, "R10 idle");
    step(1'b0, 3'd3, 2'b00, 32'h0, 3'd3, 2'b00, 3'd2, 2'b00, "R10 idle");

    // R9 random mix on both ports
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[3:1], r[5:4], $urandom, r[8:6], r[10:9], r[13:11], r[15:14],
           "R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule